// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block picks one winner per cycle from a set of N request lines. It keeps a relative order for every pair of requesters. When several requests are asserted, the grant goes to the one that no other asserted requester outranks. The grant is a one-hot vector. It is combinational from the current requests and the stored order, so a consumer can use it in the same cycle.

When the advance strobe is high on a clock edge and a grant exists, the winner drops to the bottom of the order. Every other requester then outranks it, and the order among the others does not change. The result is least-recently-served fairness. For N requesters, N(N-1)/2 bits are stored, one for each unordered pair, and the opposite direction of each pair is taken as the inverse of that bit.

No data moves through this block, so it has no valid/ready stream. The request, advance and grant pins are plain control signals. The block applies no back-pressure. A requester that is not granted simply keeps its request asserted. The advance strobe is how the consumer says that the grant of this cycle was taken.

Top module: `lrs_matrix_arb`

## Requirements
- R1: The grant vector has at most one bit set in every cycle.
- R2: The grant vector is all-zero exactly when the request vector is all-zero.
- R3: A grant bit is only set where the matching request bit is set.
- R4: After synchronous reset, a lower index outranks every higher index. For example, with all requests asserted, bit 0 is granted.
- R5: The grant goes to the asserted requester that no other asserted requester outranks under the stored pairwise order.
- R6: On a clock edge where advance is high and requester k is granted, k becomes outranked by every other requester. All other pairwise relations keep their value.
- R7: On a clock edge where advance is low, the pairwise order is unchanged.
- R8: On a clock edge where no request is asserted, the pairwise order is unchanged, even with advance high.
- R9: The grant follows a change of the request vector in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the index order |
| req | input | N | Request lines, one per requester |
| adv | input | 1 | Advance strobe; commits the current grant into the order |
| gnt | output | N | One-hot grant, or zero when nothing is requested |

## Verification
The properties assume that `req` and `adv` are known values that change only between clock edges. They also assume that the order was set by reset before the first checked edge. The bench meets this by driving every input on the falling edge from a fixed-seed random source and from directed sequences. It only begins its checks after reset has been held for two edges. The bench's reference model keeps a full N×N outranking table and applies the row-clear/column-set update on its own. This lets random request mixes, with the strobe both high and low, be compared against the design cycle by cycle.

// File: rtl/marb_pkg.sv
package marb_pkg;

  // Number of stored pair bits for n requesters.
  function automatic int tri_size(input int n);
    return n * (n - 1) / 2;
  endfunction

  // Position of the pair (hi, lo), hi > lo, inside the packed triangle.
  function automatic int tri_pos(input int hi, input int lo);
    return hi * (hi - 1) / 2 + lo;
  endfunction

endpackage

// File: rtl/marb_state.sv
// Stored pair bits. Bit tri_pos(hi,lo) set means requester hi outranks lo.
module marb_state #(
  parameter int N   = 4,
  parameter int TRI = marb_pkg::tri_size(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd,
  input  logic [N-1:0]   win,
  output logic [TRI-1:0] pair_q
);

  logic [TRI-1:0] pair_d;

  for (genvar hi = 1; hi < N; hi++) begin : g_row
    for (genvar lo = 0; lo < hi; lo++) begin : g_col
      localparam int P = marb_pkg::tri_pos(hi, lo);
      // Winner row cleared, winner column set; others keep value.
      always_comb begin
        pair_d[P] = pair_q[P];
        if (upd) begin
          if (win[hi])      pair_d[P] = 1'b0;
          else if (win[lo]) pair_d[P] = 1'b1;
        end
      end
    end
  end

  // Reset value zero: every lower index outranks every higher index.
  always_ff @(posedge clk) begin
    if (rst) pair_q <= '0;
    else     pair_q <= pair_d;
  end

endmodule

// File: rtl/marb_beats.sv
// Expand the stored triangle into a full outranking table:
// beats[a*N+b] set means requester a outranks requester b.
module marb_beats #(
  parameter int N   = 4,
  parameter int TRI = marb_pkg::tri_size(N)
) (
  input  logic [TRI-1:0] pair_q,
  output logic [N*N-1:0] beats
);

  for (genvar a = 0; a < N; a++) begin : g_a
    for (genvar b = 0; b < N; b++) begin : g_b
      if (a > b) begin : g_stored
        assign beats[a*N+b] = pair_q[marb_pkg::tri_pos(a, b)];
      end else if (a < b) begin : g_mirror
        assign beats[a*N+b] = ~pair_q[marb_pkg::tri_pos(b, a)];
      end else begin : g_diag
        assign beats[a*N+b] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/marb_pick.sv
// Each asserted request disables those it outranks; survivors are granted.
module marb_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]   req,
  input  logic [N*N-1:0] beats,
  output logic [N-1:0]   gnt
);

  logic [N-1:0] blocked;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        blocked[i] = blocked[i] | (req[j] & beats[j*N+i]);
      end
      gnt[i] = req[i] & ~blocked[i];
    end
  end

endmodule

// File: rtl/lrs_matrix_arb.sv
module lrs_matrix_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);

  localparam int TRI = marb_pkg::tri_size(N);

  logic [TRI-1:0] pair_q;
  logic [N*N-1:0] beats;
  logic           upd;

  assign upd = adv & (|gnt);

  marb_state #(.N(N), .TRI(TRI)) u_state (
    .clk   (clk),
    .rst   (rst),
    .upd   (upd),
    .win   (gnt),
    .pair_q(pair_q)
  );

  marb_beats #(.N(N), .TRI(TRI)) u_beats (
    .pair_q(pair_q),
    .beats (beats)
  );

  marb_pick #(.N(N)) u_pick (
    .req  (req),
    .beats(beats),
    .gnt  (gnt)
  );

endmodule

// File: rtl/lrs_matrix_arb_chk.sv
module lrs_matrix_arb_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic         adv,
  input logic [N-1:0] gnt
);

  logic armed;
  always_ff @(posedge clk) armed <= ~rst;

  // R1
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R2
  idle_iff_chk: assert property (@(posedge clk) disable iff (rst)
    ((req == '0) == (gnt == '0)));

  // R3
  gnt_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt & ~req) == '0));

  // R7
  hold_on_idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!adv) && $stable(req)) |-> $stable(gnt));

  // R8
  hold_on_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(req == '0) && (req == '0)) |-> (gnt == '0));

  for (genvar k = 0; k < N; k++) begin : g_k
    // R6
    served_goes_last_chk: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(adv && gnt[k]) && req[k] && ($countones(req) > 1))
        |-> !gnt[k]);
  end

endmodule

bind lrs_matrix_arb lrs_matrix_arb_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .req(req), .adv(adv), .gnt(gnt)
);

// File: tb/lrs_matrix_arb_bench.sv
module lrs_matrix_arb_bench;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic         adv = 1'b0;
  logic [N-1:0] gnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit outr [N][N]; // outr[a][b]: a outranks b

  always #2 clk = ~clk; // 250 MHz

  lrs_matrix_arb #(.N(N)) u_lrs_matrix_arb (
    .clk(clk), .rst(rst), .req(req), .adv(adv), .gnt(gnt)
  );

  function automatic void m_reset();
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        outr[a][b] = (a < b);
  endfunction

  function automatic logic [N-1:0] m_grant(input logic [N-1:0] r);
    logic [N-1:0] g = '0;
    for (int i = 0; i < N; i++) begin
      bit lost = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i && r[j] && outr[j][i]) lost = 1'b1;
      g[i] = r[i] & ~lost;
    end
    return g;
  endfunction

  function automatic void m_serve(input logic [N-1:0] g);
    for (int k = 0; k < N; k++)
      if (g[k])
        for (int j = 0; j < N; j++)
          if (j != k) begin
            outr[k][j] = 1'b0;
            outr[j][k] = 1'b1;
          end
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s gnt=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, compare after settling, then let the edge commit.
  task automatic cyc(input logic [N-1:0] r, input logic a, input string tag);
    logic [N-1:0] e;
    req = r;
    adv = a;
    #1;
    e = m_grant(r);
    check(gnt === e, tag, gnt, e);
    check($onehot0(gnt) && ((gnt & ~r) == '0), "R1/R3", gnt, e);
    @(posedge clk);
    if (a && e != '0) m_serve(e);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a7b));
    m_reset();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R4: reset order, lowest index first
    req = '1; #1;
    check(gnt === 4'b0001, "R4", gnt, 4'b0001);
    @(negedge clk);
    // R2: nothing requested means nothing granted
    req = '0; #1;
    check(gnt === '0, "R2", gnt, '0);
    // R9: same-cycle response to a new request
    req = 4'b1010; #1;
    check(gnt === 4'b0010, "R9", gnt, 4'b0010);
    @(negedge clk);

    // R5: fixed order mixes before any update
    cyc(4'b1100, 1'b0, "R5");
    cyc(4'b1000, 1'b0, "R5");

    // R6: full rotation with all requesting
    for (int n = 0; n < 2 * N; n++) cyc('1, 1'b1, "R6");

    // R7: strobe low holds the order
    cyc(4'b0110, 1'b0, "R7");
    cyc(4'b0110, 1'b0, "R7");
    cyc('1, 1'b0, "R7");

    // R8: strobe high without requests leaves the order alone
    cyc('0, 1'b1, "R8");
    cyc('0, 1'b1, "R8");
    cyc('1, 1'b0, "R8");

    // R6: a served requester loses to each single other
    cyc(4'b0101, 1'b1, "R6");
    cyc(4'b0101, 1'b1, "R6");
    cyc(4'b0101, 1'b1, "R6");

    // R5/R6/R7 mixed random traffic
    for (int n = 0; n < 1500; n++)
      cyc(N'($urandom), ($urandom % 4) != 0, "R5");

    // R4: reset restores index order after random history
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_reset();
    cyc('1, 1'b0, "R4");
    cyc(4'b1110, 1'b0, "R4");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule